// File: doc/BRIEF.md
# Power Button and Reset Sequencer

This block sits in a board controller and turns two front-panel push buttons into the supply enable, the fan enable and the active-low reset lines of a processor board. Both buttons are filtered against contact bounce. Each accepted press of the power button starts a hold-off interval. When the interval ends, a latched supply-on state flips, and the external supply enable, the fan enable and the master reset follow it.

A remote override, already resolved into single bits in this clock domain, can take over the clock-generator reset, the PCIe reset and the fan enable while its active flag is set. A request line from the processor starts a reboot. The master reset is held low for a fixed number of cycles, and then a done flag is raised that stays set until the next request. Everything runs from one reference clock. All counts are parameters, so a bench can use short values.

Top module: `pwr_rst_seq`

## Requirements
- R1: A button level reaches the logic only after two synchronizer stages and DB_CYC consecutive cycles at the new level. A pulse of fewer than DB_CYC cycles changes no output.
- R2: A press is a falling edge of the filtered power button (the button is low when pressed). When no hold-off is running, a press starts one of HOLD_CYC cycles, and the supply-on state toggles at its end. A press while a hold-off is running is ignored.
- R3: psu_on_o is the supply-on state, one register later. The state is off after reset.
- R4: fan_en_o is ovr_fan_i when ovr_active_i is high. Otherwise it is the supply-on state. It is registered.
- R5: ps_mrst_no is high only when the filtered reset button is released, the supply is on and no reboot is running. It is registered.
- R6: A rising edge on ps_reboot_req_i, after a two-stage synchronizer, starts a reboot when none is running. The reboot holds ps_mrst_no low for RB_CYC cycles and then sets reboot_done_o. The flag clears when the next reboot starts. A request during a running reboot is ignored.
- R7: pcie_rst_no is NOT ovr_pcie_rst_i when the override is active, and the filtered reset button otherwise. In both cases it is ANDed with ps_gpio_i. It is registered.
- R8: clk_rst_no is NOT ovr_clk_rst_i when the override is active, and high otherwise. It is registered.
- R9: ps_srst_no is always high, and clk_sel_o is always 2'b00.
- R10: While rst_ni is low, psu_on_o, fan_en_o, ps_mrst_no, pcie_rst_no, clk_rst_no and reboot_done_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_btn_ni | input | 1 | Raw power button, low when pressed |
| rst_btn_ni | input | 1 | Raw reset button, low when pressed |
| ps_reboot_req_i | input | 1 | Processor reboot request, rising edge acts |
| ps_gpio_i | input | 1 | Processor line gating the PCIe reset |
| ovr_active_i | input | 1 | Remote override in force |
| ovr_clk_rst_i | input | 1 | Override bit for the clock-generator reset |
| ovr_pcie_rst_i | input | 1 | Override bit for the PCIe reset |
| ovr_fan_i | input | 1 | Override bit for the fan enable |
| psu_on_o | output | 1 | Main supply enable |
| fan_en_o | output | 1 | Fan enable |
| ps_mrst_no | output | 1 | Processor master reset, active low |
| ps_srst_no | output | 1 | Processor system reset, tied high |
| pcie_rst_no | output | 1 | PCIe reset, active low |
| clk_rst_no | output | 1 | Clock-generator reset, active low |
| clk_sel_o | output | 2 | Clock-generator select, tied to zero |
| reboot_done_o | output | 1 | Set when a reboot has finished |

## Verification
The assertions assume that the override flag and its three bits are synchronous to clk_i, and that a reboot request stays high for at least one clock so the synchronizer can see it. The buttons may be fully asynchronous. The bench meets these assumptions by changing every input only on the falling clock edge. It holds each request pulse for a whole cycle and changes the override bits only while the flag is in a known state.

// File: rtl/pwr_rst_seq_pkg.sv
package pwr_rst_seq_pkg;
  typedef enum logic {
    HOLD_IDLE = 1'b0,
    HOLD_RUN  = 1'b1
  } hold_state_e;

  typedef enum logic {
    RB_IDLE = 1'b0,
    RB_RUN  = 1'b1
  } rb_state_e;
endpackage

// File: rtl/prs_debounce.sv
module prs_debounce #(
  parameter int unsigned CNT     = 491520,
  parameter bit          IDLE_LV = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic db_o
);
  localparam int unsigned CW = $clog2(CNT + 1);

  logic          s1_q, s2_q, db_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= IDLE_LV;
      s2_q  <= IDLE_LV;
      db_q  <= IDLE_LV;
      cnt_q <= '0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
      if (s2_q != db_q) begin
        if (cnt_q == CW'(CNT - 1)) begin
          db_q  <= s2_q;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign db_o = db_q;
endmodule

// File: rtl/prs_supply_toggle.sv
module prs_supply_toggle
  import pwr_rst_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 2457600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_db_i,
  output logic psu_state_o,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  hold_state_e   st_q;
  logic [CW-1:0] cnt_q;
  logic          prev_q, psu_q, press;

  // button is low when pressed: act on falling edge
  assign press = prev_q & ~btn_db_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= HOLD_IDLE;
      cnt_q  <= '0;
      prev_q <= 1'b1;
      psu_q  <= 1'b0;
    end else begin
      prev_q <= btn_db_i;
      unique case (st_q)
        HOLD_IDLE: begin
          if (press) begin
            st_q  <= HOLD_RUN;
            cnt_q <= '0;
          end
        end
        HOLD_RUN: begin
          if (cnt_q == CW'(HOLD_CYC - 1)) begin
            psu_q <= ~psu_q;
            st_q  <= HOLD_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= HOLD_IDLE;
      endcase
    end
  end

  assign psu_state_o = psu_q;
  assign busy_o      = (st_q == HOLD_RUN);
endmodule

// File: rtl/prs_reboot_timer.sv
module prs_reboot_timer
  import pwr_rst_seq_pkg::*;
#(
  parameter int unsigned RB_CYC = 24576
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic active_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(RB_CYC + 1);

  rb_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic          q1, q2, q2_d, done_q, rise;

  assign rise = q2 & ~q2_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q1     <= 1'b0;
      q2     <= 1'b0;
      q2_d   <= 1'b0;
      st_q   <= RB_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      q1   <= req_i;
      q2   <= q1;
      q2_d <= q2;
      unique case (st_q)
        RB_IDLE: begin
          if (rise) begin
            st_q   <= RB_RUN;
            cnt_q  <= '0;
            done_q <= 1'b0;
          end
        end
        RB_RUN: begin
          if (cnt_q == CW'(RB_CYC - 1)) begin
            st_q   <= RB_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= RB_IDLE;
      endcase
    end
  end

  assign active_o = (st_q == RB_RUN);
  assign done_o   = done_q;
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq #(
  parameter int unsigned DB_CYC   = 491520,
  parameter int unsigned HOLD_CYC = 2457600,
  parameter int unsigned RB_CYC   = 24576
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_btn_ni,
  input  logic       rst_btn_ni,
  input  logic       ps_reboot_req_i,
  input  logic       ps_gpio_i,
  input  logic       ovr_active_i,
  input  logic       ovr_clk_rst_i,
  input  logic       ovr_pcie_rst_i,
  input  logic       ovr_fan_i,
  output logic       psu_on_o,
  output logic       fan_en_o,
  output logic       ps_mrst_no,
  output logic       ps_srst_no,
  output logic       pcie_rst_no,
  output logic       clk_rst_no,
  output logic [1:0] clk_sel_o,
  output logic       reboot_done_o
);
  localparam int unsigned NBTN    = 2;
  localparam int unsigned IDX_PWR = 0;
  localparam int unsigned IDX_RST = 1;

  logic [NBTN-1:0] btn_raw, btn_db;
  logic            psu_state, hold_busy, rebooting;
  logic            psu_q, fan_q, mrst_q, pcie_q, clkrst_q;

  assign btn_raw[IDX_PWR] = pwr_btn_ni;
  assign btn_raw[IDX_RST] = rst_btn_ni;

  for (genvar g = 0; g < NBTN; g++) begin : g_db
    prs_debounce #(
      .CNT     (DB_CYC),
      .IDLE_LV (1'b1)
    ) u_db (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (btn_raw[g]),
      .db_o   (btn_db[g])
    );
  end

  prs_supply_toggle #(
    .HOLD_CYC (HOLD_CYC)
  ) u_toggle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .btn_db_i    (btn_db[IDX_PWR]),
    .psu_state_o (psu_state),
    .busy_o      (hold_busy)
  );

  prs_reboot_timer #(
    .RB_CYC (RB_CYC)
  ) u_reboot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (ps_reboot_req_i),
    .active_o (rebooting),
    .done_o   (reboot_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psu_q    <= 1'b0;
      fan_q    <= 1'b0;
      mrst_q   <= 1'b0;
      pcie_q   <= 1'b0;
      clkrst_q <= 1'b0;
    end else begin
      psu_q    <= psu_state;
      fan_q    <= ovr_active_i ? ovr_fan_i : psu_state;
      mrst_q   <= btn_db[IDX_RST] & psu_state & ~rebooting;
      pcie_q   <= (ovr_active_i ? ~ovr_pcie_rst_i : btn_db[IDX_RST]) & ps_gpio_i;
      clkrst_q <= ovr_active_i ? ~ovr_clk_rst_i : 1'b1;
    end
  end

  assign psu_on_o    = psu_q;
  assign fan_en_o    = fan_q;
  assign ps_mrst_no  = mrst_q;
  assign pcie_rst_no = pcie_q;
  assign clk_rst_no  = clkrst_q;
  assign ps_srst_no  = 1'b1;
  assign clk_sel_o   = 2'b00;
endmodule

// File: rtl/pwr_rst_seq_chk.sv
module pwr_rst_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ovr_active_i,
  input logic ovr_clk_rst_i,
  input logic ovr_fan_i,
  input logic ps_gpio_i,
  input logic psu_on_o,
  input logic fan_en_o,
  input logic ps_mrst_no,
  input logic pcie_rst_no,
  input logic clk_rst_no,
  input logic psu_state,
  input logic hold_busy,
  input logic rebooting
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_TOGGLE_ONLY_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && psu_state != $past(psu_state)) |-> $past(hold_busy)); // R2

  AST_MRST_NEEDS_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psu_on_o |-> !ps_mrst_no); // R5

  AST_MRST_LOW_IN_REBOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rebooting |=> !ps_mrst_no); // R6

  AST_FAN_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(ovr_active_i)) |-> (fan_en_o == $past(ovr_fan_i))); // R4

  AST_PCIE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(ps_gpio_i)) |-> !pcie_rst_no); // R7

  AST_CLKRST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !$past(ovr_active_i)) |-> clk_rst_no); // R8

  AST_CLKRST_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(ovr_active_i)) |-> (clk_rst_no == !$past(ovr_clk_rst_i))); // R8
endmodule

bind pwr_rst_seq pwr_rst_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ovr_active_i  (ovr_active_i),
  .ovr_clk_rst_i (ovr_clk_rst_i),
  .ovr_fan_i     (ovr_fan_i),
  .ps_gpio_i     (ps_gpio_i),
  .psu_on_o      (psu_on_o),
  .fan_en_o      (fan_en_o),
  .ps_mrst_no    (ps_mrst_no),
  .pcie_rst_no   (pcie_rst_no),
  .clk_rst_no    (clk_rst_no),
  .psu_state     (psu_state),
  .hold_busy     (hold_busy),
  .rebooting     (rebooting)
);

// File: tb/pwr_rst_seq_tb.sv
`timescale 1ns/1ps
module pwr_rst_seq_tb;
  localparam int DB   = 8;
  localparam int HOLD = 60;
  localparam int RB   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_b = 1'b1, rst_b = 1'b1, req = 1'b0, gpio = 1'b1;
  logic ovr = 1'b0, o_clk = 1'b0, o_pcie = 1'b0, o_fan = 1'b0;
  logic psu_on, fan_en, mrst_n, srst_n, pcie_n, clkrst_n, done;
  logic [1:0] clk_sel;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pwr_rst_seq #(.DB_CYC(DB), .HOLD_CYC(HOLD), .RB_CYC(RB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_btn_ni(pwr_b), .rst_btn_ni(rst_b),
    .ps_reboot_req_i(req), .ps_gpio_i(gpio), .ovr_active_i(ovr),
    .ovr_clk_rst_i(o_clk), .ovr_pcie_rst_i(o_pcie), .ovr_fan_i(o_fan),
    .psu_on_o(psu_on), .fan_en_o(fan_en), .ps_mrst_no(mrst_n), .ps_srst_no(srst_n),
    .pcie_rst_no(pcie_n), .clk_rst_no(clkrst_n), .clk_sel_o(clk_sel),
    .reboot_done_o(done)
  );

  // behavioural reference model
  bit ps1, ps2, pdb, rs1, rs2, rdb, pprev, busy, psu, q1, q2, q2d, rbing, mdone;
  int pcnt, rcnt, hcnt, rbcnt;
  bit e_psu, e_fan, e_mrst, e_pcie, e_clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps1 <= 1; ps2 <= 1; pdb <= 1; pcnt <= 0;
      rs1 <= 1; rs2 <= 1; rdb <= 1; rcnt <= 0;
      pprev <= 1; busy <= 0; hcnt <= 0; psu <= 0;
      q1 <= 0; q2 <= 0; q2d <= 0; rbing <= 0; rbcnt <= 0; mdone <= 0;
      e_psu <= 0; e_fan <= 0; e_mrst <= 0; e_pcie <= 0; e_clk <= 0;
    end else begin
      ps1 <= pwr_b; ps2 <= ps1;
      if (ps2 != pdb) begin
        if (pcnt == DB - 1) begin pdb <= ps2; pcnt <= 0; end
        else pcnt <= pcnt + 1;
      end else pcnt <= 0;
      rs1 <= rst_b; rs2 <= rs1;
      if (rs2 != rdb) begin
        if (rcnt == DB - 1) begin rdb <= rs2; rcnt <= 0; end
        else rcnt <= rcnt + 1;
      end else rcnt <= 0;
      pprev <= pdb;
      if (busy) begin
        if (hcnt == HOLD - 1) begin psu <= !psu; busy <= 0; end
        else hcnt <= hcnt + 1;
      end else if (pprev && !pdb) begin busy <= 1; hcnt <= 0; end
      q1 <= req; q2 <= q1; q2d <= q2;
      if (rbing) begin
        if (rbcnt == RB - 1) begin rbing <= 0; mdone <= 1; end
        else rbcnt <= rbcnt + 1;
      end else if (q2 && !q2d) begin rbing <= 1; rbcnt <= 0; mdone <= 0; end
      e_psu  <= psu;
      e_fan  <= ovr ? o_fan : psu;
      e_mrst <= rdb && psu && !rbing;
      e_pcie <= (ovr ? !o_pcie : rdb) && gpio;
      e_clk  <= ovr ? !o_clk : 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      chk(psu_on == e_psu,   "R3 psu_on",   psu_on,   e_psu);
      chk(fan_en == e_fan,   "R4 fan_en",   fan_en,   e_fan);
      chk(mrst_n == e_mrst,  "R5 mrst_n",   mrst_n,   e_mrst);
      chk(pcie_n == e_pcie,  "R7 pcie_n",   pcie_n,   e_pcie);
      chk(clkrst_n == e_clk, "R8 clkrst_n", clkrst_n, e_clk);
      chk(done == mdone,     "R6 done",     done,     mdone);
      chk(srst_n == 1'b1 && clk_sel == 2'b00, "R9 tie-offs", {clk_sel, srst_n}, 1);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    cyc(5);
    chk(!psu_on && !fan_en && !mrst_n && !pcie_n && !clkrst_n && !done, "R10 reset state",
        {psu_on, fan_en, mrst_n, pcie_n, clkrst_n, done}, 0);
    rst_n = 1'b1;
    cyc(5);
    // R1: short glitch ignored
    pwr_b = 0; cyc(4); pwr_b = 1; cyc(30);
    chk(psu_on == 1'b0, "R1 glitch no toggle", psu_on, 0);
    // R2: press, then second press inside hold-off
    pwr_b = 0; cyc(15); pwr_b = 1; cyc(15);
    pwr_b = 0; cyc(15); pwr_b = 1; cyc(100);
    chk(psu_on == 1'b1, "R2 single toggle", psu_on, 1);
    chk(mrst_n == 1'b1, "R5 mrst released", mrst_n, 1);
    // R1: short reset-button glitch
    rst_b = 0; cyc(4); rst_b = 1; cyc(20);
    chk(mrst_n == 1'b1, "R1 rst glitch ignored", mrst_n, 1);
    // R5/R7: reset button
    rst_b = 0; cyc(15);
    chk(mrst_n == 1'b0, "R5 button asserts mrst", mrst_n, 0);
    chk(pcie_n == 1'b0, "R7 button asserts pcie", pcie_n, 0);
    rst_b = 1; cyc(20);
    // R7: gpio gate
    gpio = 0; cyc(5);
    chk(pcie_n == 1'b0, "R7 gpio low", pcie_n, 0);
    gpio = 1; cyc(3);
    // R4/R8: override patterns
    ovr = 1;
    for (int v = 0; v < 8; v++) begin
      {o_fan, o_pcie, o_clk} = 3'(v);
      cyc(3);
      chk(fan_en == o_fan && clkrst_n == !o_clk && pcie_n == !o_pcie, "R4 R8 override",
          {fan_en, clkrst_n, pcie_n}, {o_fan, !o_clk, !o_pcie});
    end
    ovr = 0; o_fan = 0; o_pcie = 0; o_clk = 0; cyc(3);
    // R6: reboot, retrigger during reboot ignored
    req = 1; cyc(1); req = 0; cyc(4);
    req = 1; cyc(1); req = 0; cyc(20);
    chk(done == 1'b1 && mrst_n == 1'b1, "R6 reboot done", {done, mrst_n}, 3);
    req = 1; cyc(1); req = 0; cyc(4);
    chk(done == 1'b0 && mrst_n == 1'b0, "R6 new reboot clears done", {done, mrst_n}, 0);
    cyc(15);
    // R3: power off
    pwr_b = 0; cyc(15); pwr_b = 1; cyc(100);
    chk(psu_on == 1'b0 && fan_en == 1'b0, "R3 supply off", {psu_on, fan_en}, 0);
    // R10: reset mid-run
    rst_n = 0; cyc(3);
    chk(!psu_on && !mrst_n && !pcie_n && !clkrst_n && !done, "R10 reset again",
        {psu_on, mrst_n, pcie_n, clkrst_n, done}, 0);
    rst_n = 1; cyc(5);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end
endmodule